// File: doc/BRIEF.md
# E1 Performance Error Counter Bank

This block keeps three running error tallies for an E1 receive path: CRC4 submultiframe errors, far-end block errors reported through received E-bits, and frame alignment signal (FAS) errors. The framer supplies one-cycle event strobes, its synchronization status, and the current frame number within the CRC4 multiframe. A one-second timing pulse moves each live tally into a holding register and restarts the tally. A host reads the held values through a byte-wide read port.

The CRC4 and E-bit tallies are gated by the synchronization state. They freeze while basic frame alignment or CRC4 multiframe alignment is lost. They keep counting when only the channel-associated-signalling multiframe alignment is lost. The 12-bit FAS tally has no byte of its own. Its two halves sit in the spare upper bits of the high bytes of the other two tallies.

Top module: `e1_perf_counters`

## Requirements
- R1: With `fas_sync_lost` and `mf_sync_lost` both low, each `crc_err_stb` cycle adds one to the 10-bit CRC4 tally. The tally wraps from 1023 to 0 and has no saturation.
- R2: The 10-bit E-bit tally adds one only in a cycle where all of these hold: `ebit_stb` is high, `ebit_val` is 0, `crc4_mode` is high, and `frame_num` is 13 or 15. Any other cycle leaves it unchanged.
- R3: While `fas_sync_lost` or `mf_sync_lost` is high, neither the CRC4 tally nor the E-bit tally changes, except when a `sec_tick` restarts them.
- R4: `cas_sync_lost` has no effect on any tally.
- R5: The 12-bit FAS tally adds one per `fas_err_stb` cycle while `fas_sync_lost` is low. It is frozen while `fas_sync_lost` is high. It saturates at 4095.
- R6: On a `sec_tick` cycle, each holding register takes its tally's value before that edge. At the same edge each tally restarts at 1 if that tally's qualified event is present in the tick cycle, and at 0 otherwise.
- R7: Reads return only the holding registers, with this layout:
  - Byte address 0x02: FAS bits 11:6 in bits 7:2, and CRC4 bits 9:8 in bits 1:0.
  - Byte address 0x03: CRC4 bits 7:0.
  - Byte address 0x04: FAS bits 5:0 in bits 7:2, and E-bit bits 9:8 in bits 1:0.
  - Byte address 0x05: E-bit bits 7:0.
  - `rd_data` follows `rd_addr` with no clock delay.
- R8: Any `rd_addr` other than 0x02 to 0x05 returns 0x00.
- R9: Reset (`rst_n` low) clears all tallies and holding registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-second interval pulse |
| crc_err_stb | input | 1 | CRC4 submultiframe error event |
| ebit_stb | input | 1 | An E-bit was received this cycle |
| ebit_val | input | 1 | Value of that received E-bit |
| fas_err_stb | input | 1 | FAS error event |
| frame_num | input | 4 | Frame number within the CRC4 multiframe |
| crc4_mode | input | 1 | CRC4 multiframe operation enabled |
| fas_sync_lost | input | 1 | Frame alignment lost |
| mf_sync_lost | input | 1 | CRC4 multiframe alignment lost |
| cas_sync_lost | input | 1 | Signalling multiframe alignment lost |
| rd_addr | input | 8 | Read byte address |
| rd_data | output | 8 | Read byte |

## Verification
The checker holds several rules on every cycle:
- The CRC4 tally is frozen while either sync-loss flag is high, and otherwise never moves by more than one.
- The FAS tally stays at 4095 once it gets there, and is frozen while frame alignment is lost.
- Holding registers change only at a tick, and then take exactly the previous tally.
- Unmapped addresses read zero.

Only the bench scenarios can show which events actually count, by comparing every read byte against a behavioural model. These cover:
- E-bit qualification by frame number, value and mode.
- The lack of effect of signalling multiframe loss.
- The 1024 wrap.
- An event landing on the tick cycle.
- The bit packing across the four bytes.

// File: rtl/e1_pc_pkg.sv
package e1_pc_pkg;
   localparam int DATA_W        = 8;
   localparam int EBIT_FRAME_A  = 13;
   localparam int EBIT_FRAME_B  = 15;
   localparam int OFS_CRC_HI    = 0;
   localparam int OFS_CRC_LO    = 1;
   localparam int OFS_EB_HI     = 2;
   localparam int OFS_EB_LO     = 3;
   localparam int NUM_BYTES     = 4;

   typedef struct packed {
      logic crc;
      logic ebit;
      logic fas;
   } pc_inc_t;
endpackage

// File: rtl/e1_pc_qual.sv
module e1_pc_qual
   import e1_pc_pkg::*;
#(
   parameter int FRAME_W   = 4,
   parameter bit CAS_GATES = 1'b0
) (
   input  logic               crc_err_stb,
   input  logic               ebit_stb,
   input  logic               ebit_val,
   input  logic               fas_err_stb,
   input  logic [FRAME_W-1:0] frame_num,
   input  logic               crc4_mode,
   input  logic               fas_sync_lost,
   input  logic               mf_sync_lost,
   input  logic               cas_sync_lost,
   output pc_inc_t            inc
);
   localparam logic [FRAME_W-1:0] FR_A = FRAME_W'(EBIT_FRAME_A);
   localparam logic [FRAME_W-1:0] FR_B = FRAME_W'(EBIT_FRAME_B);

   logic in_sync;
   logic ebit_slot;

   generate
      if (CAS_GATES) begin : g_cas_gate
         assign in_sync = !fas_sync_lost && !mf_sync_lost && !cas_sync_lost;
      end else begin : g_cas_ignore
         logic unused_cas;
         assign unused_cas = cas_sync_lost;
         assign in_sync    = !fas_sync_lost && !mf_sync_lost;
      end
   endgenerate

   assign ebit_slot = crc4_mode && ((frame_num == FR_A) || (frame_num == FR_B));

   always_comb begin
      inc      = '0;
      inc.crc  = crc_err_stb && in_sync;
      inc.ebit = ebit_stb && !ebit_val && ebit_slot && in_sync;
      inc.fas  = fas_err_stb && !fas_sync_lost;
   end
endmodule

// File: rtl/e1_pc_counter.sv
module e1_pc_counter #(
   parameter int WIDTH    = 10,
   parameter bit SATURATE = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             inc,
   output logic [WIDTH-1:0] live,
   output logic [WIDTH-1:0] held
);
   localparam logic [WIDTH-1:0] TOP_VAL = '1;
   localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

   logic [WIDTH-1:0] bumped;

   generate
      if (SATURATE) begin : g_sat
         assign bumped = (live == TOP_VAL) ? live : live + ONE;
      end else begin : g_wrap
         assign bumped = live + ONE;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live <= '0;
         held <= '0;
      end else if (tick) begin
         held <= live;
         live <= inc ? ONE : '0;
      end else if (inc) begin
         live <= bumped;
      end
   end
endmodule

// File: rtl/e1_pc_regmap.sv
module e1_pc_regmap
   import e1_pc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int BASE   = 2,
   parameter int CRC_W  = 10,
   parameter int EB_W   = 10,
   parameter int FAS_W  = 12
) (
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CRC_W-1:0]  crc_held,
   input  logic [EB_W-1:0]   eb_held,
   input  logic [FAS_W-1:0]  fas_held,
   output logic [DATA_W-1:0] rd_data
);
   localparam int FAS_HALF = FAS_W / 2;
   localparam logic [ADDR_W-1:0] A_CRC_HI = ADDR_W'(BASE + OFS_CRC_HI);
   localparam logic [ADDR_W-1:0] A_CRC_LO = ADDR_W'(BASE + OFS_CRC_LO);
   localparam logic [ADDR_W-1:0] A_EB_HI  = ADDR_W'(BASE + OFS_EB_HI);
   localparam logic [ADDR_W-1:0] A_EB_LO  = ADDR_W'(BASE + OFS_EB_LO);

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CRC_HI)
         rd_data = {fas_held[FAS_W-1 -: FAS_HALF], crc_held[CRC_W-1:DATA_W]};
      else if (rd_addr == A_CRC_LO)
         rd_data = crc_held[DATA_W-1:0];
      else if (rd_addr == A_EB_HI)
         rd_data = {fas_held[FAS_HALF-1:0], eb_held[EB_W-1:DATA_W]};
      else if (rd_addr == A_EB_LO)
         rd_data = eb_held[DATA_W-1:0];
   end
endmodule

// File: rtl/e1_perf_counters.sv
module e1_perf_counters
   import e1_pc_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int BASE      = 2,
   parameter int FRAME_W   = 4,
   parameter int CRC_W     = 10,
   parameter int EB_W      = 10,
   parameter int FAS_W     = 12,
   parameter bit CAS_GATES = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_tick,
   input  logic               crc_err_stb,
   input  logic               ebit_stb,
   input  logic               ebit_val,
   input  logic               fas_err_stb,
   input  logic [FRAME_W-1:0] frame_num,
   input  logic               crc4_mode,
   input  logic               fas_sync_lost,
   input  logic               mf_sync_lost,
   input  logic               cas_sync_lost,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [7:0]         rd_data
);
   localparam int HI_W     = CRC_W - DATA_W;
   localparam int FAS_HALF = FAS_W / 2;

   generate
      if (CRC_W != EB_W)
         $error("CRC and E-bit tallies must share one width");
      if (HI_W < 1 || HI_W + FAS_HALF != DATA_W || (FAS_W % 2) != 0)
         $error("tally widths do not pack into the high bytes");
      if (BASE < 0 || BASE + NUM_BYTES > (1 << ADDR_W))
         $error("register window does not fit the address width");
      if ((1 << FRAME_W) <= EBIT_FRAME_B)
         $error("frame number too narrow for E-bit frames");
   endgenerate

   pc_inc_t          inc;
   logic [CRC_W-1:0] crc_live, crc_held;
   logic [EB_W-1:0]  eb_live, eb_held;
   logic [FAS_W-1:0] fas_live, fas_held;

   e1_pc_qual #(.FRAME_W(FRAME_W), .CAS_GATES(CAS_GATES)) u_qual (
      .crc_err_stb  (crc_err_stb),
      .ebit_stb     (ebit_stb),
      .ebit_val     (ebit_val),
      .fas_err_stb  (fas_err_stb),
      .frame_num    (frame_num),
      .crc4_mode    (crc4_mode),
      .fas_sync_lost(fas_sync_lost),
      .mf_sync_lost (mf_sync_lost),
      .cas_sync_lost(cas_sync_lost),
      .inc          (inc)
   );

   e1_pc_counter #(.WIDTH(CRC_W), .SATURATE(1'b0)) u_crc (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .inc(inc.crc),
      .live(crc_live), .held(crc_held)
   );

   e1_pc_counter #(.WIDTH(EB_W), .SATURATE(1'b0)) u_ebit (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .inc(inc.ebit),
      .live(eb_live), .held(eb_held)
   );

   e1_pc_counter #(.WIDTH(FAS_W), .SATURATE(1'b1)) u_fas (
      .clk(clk), .rst_n(rst_n), .tick(sec_tick), .inc(inc.fas),
      .live(fas_live), .held(fas_held)
   );

   e1_pc_regmap #(
      .ADDR_W(ADDR_W), .BASE(BASE), .CRC_W(CRC_W), .EB_W(EB_W), .FAS_W(FAS_W)
   ) u_map (
      .rd_addr (rd_addr),
      .crc_held(crc_held),
      .eb_held (eb_held),
      .fas_held(fas_held),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/e1_pc_chk.sv
module e1_pc_chk #(
   parameter int ADDR_W = 8,
   parameter int BASE   = 2,
   parameter int CRC_W  = 10,
   parameter int EB_W   = 10,
   parameter int FAS_W  = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sec_tick,
   input logic              fas_sync_lost,
   input logic              mf_sync_lost,
   input logic [CRC_W-1:0]  crc_live,
   input logic [CRC_W-1:0]  crc_held,
   input logic [EB_W-1:0]   eb_live,
   input logic [EB_W-1:0]   eb_held,
   input logic [FAS_W-1:0]  fas_live,
   input logic [FAS_W-1:0]  fas_held,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [7:0]        rd_data
);
   localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(BASE + 3);
   localparam logic [FAS_W-1:0]  FAS_MX = '1;

   p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick |=> (crc_live == $past(crc_live)) || (crc_live == $past(crc_live) + 1'b1));

   p_hold_loss_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fas_sync_lost || mf_sync_lost) && !sec_tick |=>
         (crc_live == $past(crc_live)) && (eb_live == $past(eb_live)));

   p_fas_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fas_live == FAS_MX) && !sec_tick |=> fas_live == FAS_MX);

   p_fas_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      fas_sync_lost && !sec_tick |=> $stable(fas_live));

   p_tick_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> (crc_held == $past(crc_live)) && (eb_held == $past(eb_live))
                   && (fas_held == $past(fas_live)));

   p_tick_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sec_tick |=> (crc_live <= 1) && (eb_live <= 1) && (fas_live <= 1));

   p_held_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sec_tick |=> $stable(crc_held) && $stable(eb_held) && $stable(fas_held));

   p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr < A_LO || rd_addr > A_HI) |-> rd_data == 8'h00);
endmodule

bind e1_perf_counters e1_pc_chk #(
   .ADDR_W(ADDR_W), .BASE(BASE), .CRC_W(CRC_W), .EB_W(EB_W), .FAS_W(FAS_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .sec_tick     (sec_tick),
   .fas_sync_lost(fas_sync_lost),
   .mf_sync_lost (mf_sync_lost),
   .crc_live     (crc_live),
   .crc_held     (crc_held),
   .eb_live      (eb_live),
   .eb_held      (eb_held),
   .fas_live     (fas_live),
   .fas_held     (fas_held),
   .rd_addr      (rd_addr),
   .rd_data      (rd_data)
);

// File: tb/tb_e1_perf_counters.sv
module tb_e1_perf_counters;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       sec_tick, crc_err_stb, ebit_stb, ebit_val, fas_err_stb;
   logic [3:0] frame_num;
   logic       crc4_mode, fas_sync_lost, mf_sync_lost, cas_sync_lost;
   logic [7:0] rd_addr;
   logic [7:0] rd_data;

   int    n_cmp = 0;
   int    n_bad = 0;
   string phase_req = "R9";
   bit    rand_addr = 1'b0;
   int    rot = 0;

   int m_crc, m_eb, m_fas, h_crc, h_eb, h_fas;

   always #(CLK_PERIOD/2) clk = ~clk;

   e1_perf_counters dut (
      .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .crc_err_stb(crc_err_stb),
      .ebit_stb(ebit_stb), .ebit_val(ebit_val), .fas_err_stb(fas_err_stb),
      .frame_num(frame_num), .crc4_mode(crc4_mode), .fas_sync_lost(fas_sync_lost),
      .mf_sync_lost(mf_sync_lost), .cas_sync_lost(cas_sync_lost),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // behavioural reference, updated on each rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_crc = 0; m_eb = 0; m_fas = 0; h_crc = 0; h_eb = 0; h_fas = 0;
      end else begin
         bit ok, ic, ie, iff_;
         ok   = !fas_sync_lost && !mf_sync_lost;
         ic   = crc_err_stb && ok;
         ie   = ebit_stb && !ebit_val && crc4_mode && ok &&
                (frame_num == 4'd13 || frame_num == 4'd15);
         iff_ = fas_err_stb && !fas_sync_lost;
         if (sec_tick) begin
            h_crc = m_crc; h_eb = m_eb; h_fas = m_fas;
            m_crc = ic; m_eb = ie; m_fas = iff_;
         end else begin
            m_crc = (m_crc + ic) % 1024;
            m_eb  = (m_eb + ie) % 1024;
            m_fas = (m_fas + iff_ > 4095) ? 4095 : m_fas + iff_;
         end
      end
   end

   function automatic int exp_byte(input int a);
      case (a)
         2: return (((h_fas >> 6) & 63) << 2) | ((h_crc >> 8) & 3);
         3: return h_crc & 255;
         4: return ((h_fas & 63) << 2) | ((h_eb >> 8) & 3);
         5: return h_eb & 255;
         default: return 0;
      endcase
   endfunction

   task automatic cyc();
      int e;
      @(negedge clk);
      e = exp_byte(int'(rd_addr));
      n_cmp++;
      if (int'(rd_data) != e) begin
         n_bad++;
         $display("FAIL %s addr=%02h actual=%02h expected=%02h", phase_req, rd_addr, rd_data, e);
      end
      if (rand_addr) rd_addr = 8'($urandom);
      else begin rd_addr = 8'(2 + (rot % 4)); rot++; end
      sec_tick = 0; crc_err_stb = 0; ebit_stb = 0; fas_err_stb = 0;
   endtask

   task automatic tick_read();
      cyc();
      sec_tick = 1;
      repeat (8) cyc();
   endtask

   initial begin
      rst_n = 0; sec_tick = 0; crc_err_stb = 0; ebit_stb = 0; ebit_val = 1;
      fas_err_stb = 0; frame_num = 0; crc4_mode = 1; fas_sync_lost = 0;
      mf_sync_lost = 0; cas_sync_lost = 0; rd_addr = 8'h02;
      // R9: reset state on all four bytes
      repeat (6) cyc();
      rst_n = 1;
      repeat (4) cyc();

      // R1: CRC4 counting and packing (R7)
      phase_req = "R1";
      for (int i = 0; i < 300; i++) begin cyc(); crc_err_stb = (i % 3 != 1); end
      tick_read();
      // R1: wrap past 1023
      for (int i = 0; i < 1030; i++) begin cyc(); crc_err_stb = 1; end
      tick_read();

      // R2: E-bit qualification
      phase_req = "R2";
      for (int i = 0; i < 600; i++) begin
         cyc();
         ebit_stb  = $urandom % 2;
         ebit_val  = $urandom % 2;
         frame_num = (i % 2 == 0) ? 4'(13 + 2 * ($urandom % 2)) : 4'($urandom);
         crc4_mode = ($urandom % 4) != 0;
      end
      crc4_mode = 1;
      tick_read();

      // R3: frozen during FAS or CRC4 multiframe loss
      phase_req = "R3";
      for (int i = 0; i < 200; i++) begin
         cyc();
         fas_sync_lost = (i < 100); mf_sync_lost = (i >= 100);
         crc_err_stb = 1; ebit_stb = 1; ebit_val = 0; frame_num = 4'd15;
      end
      tick_read();
      fas_sync_lost = 0; mf_sync_lost = 0;

      // R4: signalling multiframe loss has no effect
      phase_req = "R4";
      cas_sync_lost = 1;
      for (int i = 0; i < 150; i++) begin
         cyc(); crc_err_stb = 1; ebit_stb = 1; ebit_val = 0; frame_num = 4'd13; fas_err_stb = 1;
      end
      tick_read();
      cas_sync_lost = 0;

      // R5: FAS saturation and gating
      phase_req = "R5";
      for (int i = 0; i < 4110; i++) begin cyc(); fas_err_stb = 1; end
      tick_read();
      for (int i = 0; i < 60; i++) begin cyc(); fas_err_stb = 1; fas_sync_lost = (i % 2 == 0); end
      tick_read();
      fas_sync_lost = 0;

      // R6: event in the tick cycle goes to the new interval
      phase_req = "R6";
      for (int i = 0; i < 5; i++) begin cyc(); crc_err_stb = 1; end
      cyc(); sec_tick = 1; crc_err_stb = 1; fas_err_stb = 1;
      ebit_stb = 1; ebit_val = 0; frame_num = 4'd13;
      repeat (4) cyc();
      tick_read();

      // R8: unmapped reads
      phase_req = "R8";
      rand_addr = 1;
      repeat (200) cyc();

      // R7: mixed traffic with random reads
      phase_req = "R7";
      for (int i = 0; i < 3000; i++) begin
         cyc();
         crc_err_stb = $urandom % 2; ebit_stb = $urandom % 2; ebit_val = $urandom % 2;
         fas_err_stb = $urandom % 2; frame_num = 4'($urandom);
         fas_sync_lost = ($urandom % 8) == 0; mf_sync_lost = ($urandom % 8) == 0;
         cas_sync_lost = $urandom % 2; crc4_mode = ($urandom % 8) != 0;
         sec_tick = (i % 250) == 249;
      end
      rand_addr = 0;
      repeat (8) cyc();

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog R9 actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule